// File: doc/BRIEF.md
# Gray-Timestamp Pixel Digitizer Back End

This block is the digital side of an array of single-slope pixel converters. A shared binary counter runs through a conversion window, and its value goes out to every pixel in Gray code on one timestamp bus. Each pixel watches its own comparator line. The first time that line is seen high inside the window, the pixel freezes the Gray code on the bus. In wide mode the pixel also freezes a local count of how many times the bus has wrapped. This gives one extra result bit, so the ramp takes twice as many cycles.

Each pixel keeps two registers. The working register collects the current frame. The hold register keeps the last completed frame for readout. A frame strobe taken while the array is idle does three things: it converts each working code to binary, copies it into the hold register, and re-arms every pixel for the new window. The previous frame can therefore be read out through an addressed port while the next one converts. A pixel whose comparator never fires in a window reports full scale.

Top module: `slope_stamp_array`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `rd_valid` are 0 and every pixel reads back 0 on `rd_data`.
- R2: A `frame_strobe` sampled high while `busy` is 0 starts a window. `busy` is 1 from the next cycle for exactly 256 cycles in narrow mode and 512 cycles in wide mode, then returns to 0.
- R3: In narrow mode (`wide_mode`=0 at the start), a pixel reports t on `rd_data`. Here t is the index of the first window cycle in which its comparator is high, counted from 0 in the cycle after the strobe is taken. Every value 0..255 is reachable and bit 8 is 0.
- R4: In wide mode, the same rule covers t = 0..511. Bit 8 is the pixel's local count of bus wraps and bits 7..0 are the converted Gray code.
- R5: A pixel whose comparator is never high inside the window reports full scale: 255 in narrow mode, 511 in wide mode.
- R6: Only the first comparator event in a window is kept. Any later high level or pulse in the same window has no effect on that pixel's result.
- R7: Results of a window appear on the read port only after the strobe that starts the next window. They stay unchanged throughout that next window, whatever the comparators do.
- R8: A `frame_strobe` while `busy` is 1 is ignored: the window is neither restarted nor lengthened, and results are unaffected.
- R9: `wide_mode` is sampled only when a window starts. Changing it during a window changes neither that window's length nor its results.
- R10: `rd_valid` rises on the first accepted strobe that follows a completed window and then stays 1 until reset.
- R11: `rd_data` shows, combinationally, the held result of the pixel selected by `rd_addr` (pixel index 0..NPIX-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one counter step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_strobe | input | 1 | Starts a window and commits the last one, when idle |
| wide_mode | input | 1 | 1 selects 9-bit results, 0 selects 8-bit |
| comp | input | NPIX | Per-pixel comparator level, bit i for pixel i |
| rd_addr | input | $clog2(NPIX) | Pixel index to read |
| rd_data | output | CODE_W+EXT_W | Held result of the addressed pixel |
| rd_valid | output | 1 | Hold registers contain a completed window |
| busy | output | 1 | A conversion window is running |

## Verification
The sweeps give each of the 64 pixels a distinct firing cycle, across enough frames that every code in both modes is captured. A slip in counter-to-Gray timing, or a bad XOR prefix, would show up as a shifted or missing code. A missing or early wrap count would split the wide range at 256. Some frames fire in short pulses with a second, later pulse. A latch that is not disarmed after capture would report the later cycle. Other frames flip the mode and pulse the strobe mid-window: a design that re-samples either would change the window length or restart the counter. Every held result is read while the next frame's comparators are firing, so a single-buffered store would return the new codes early. Windows that end with unfired pixels must produce 255 or 511, not a stale or zero value.

// File: rtl/stamp_pkg.sv
// Shared constants and helpers for the Gray-timestamp pixel array.
// Assumes the wide mode adds EXT_W bits on top of the broadcast code width.
package stamp_pkg;

    localparam int STAMP_BITS = 8;
    localparam int EXTRA_BITS = 1;
    localparam int ARRAY_PIXELS = 64;

    // Number of counter cycles in one conversion window for a given mode.
    function automatic int window_cycles(input int code_w, input int ext_w, input logic wide);
        return wide ? (1 << (code_w + ext_w)) : (1 << code_w);
    endfunction

endpackage

// File: rtl/stamp_gen.sv
// Window sequencer and timestamp broadcaster.
// Runs a binary counter through one window per accepted strobe, drives the
// Gray-coded low bits onto the shared bus, and flags wraps, window end and
// commit. Assumes a strobe is honoured only while idle.
module stamp_gen #(
    parameter int CODE_W = 8,
    parameter int EXT_W  = 1,
    localparam int CNT_W = CODE_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              wide_mode,
    output logic              busy,
    output logic              arm,
    output logic              commit,
    output logic              window_end,
    output logic              wrap_tick,
    output logic              wide_q,
    output logic [CODE_W-1:0] gray_bus,
    output logic              rd_valid
);

    localparam logic [CNT_W-1:0] LAST_WIDE   = '1;
    localparam logic [CNT_W-1:0] LAST_NARROW = {{EXT_W{1'b0}}, {CODE_W{1'b1}}};

    logic [CNT_W-1:0] cnt;
    logic             done_q;
    logic             last_hit;

    // Decode strobe acceptance, last cycle and bus wrap from the counter state.
    always_comb begin
        arm        = frame_strobe & ~busy;
        commit     = arm & done_q;
        last_hit   = (cnt == (wide_q ? LAST_WIDE : LAST_NARROW));
        window_end = busy & last_hit;
        wrap_tick  = busy & wide_q & (&cnt[CODE_W-1:0]) & ~last_hit;
        gray_bus   = cnt[CODE_W-1:0] ^ (cnt[CODE_W-1:0] >> 1);
    end

    // Counter, run flag and the mode latched at window start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy   <= 1'b0;
            wide_q <= 1'b0;
        end else if (arm) begin
            cnt    <= '0;
            busy   <= 1'b1;
            wide_q <= wide_mode;
        end else if (busy) begin
            if (last_hit) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Track whether a finished window waits for commit, and readout validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            if (window_end) begin
                done_q <= 1'b1;
            end else if (commit) begin
                done_q <= 1'b0;
            end
            if (commit) begin
                rd_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/stamp_pixel.sv
// One pixel's digital back end.
// Freezes the broadcast Gray code on its first comparator event in a window,
// counts bus wraps locally for the extra bit, and on commit converts the
// frozen code to binary into a hold register (double buffering).
// Assumes the comparator level is synchronous to clk.
module stamp_pixel #(
    parameter int CODE_W = 8,
    parameter int EXT_W  = 1,
    localparam int RES_W = CODE_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              commit,
    input  logic              busy,
    input  logic              window_end,
    input  logic              wrap_tick,
    input  logic              wide_q,
    input  logic [CODE_W-1:0] gray_bus,
    input  logic              comp,
    output logic [RES_W-1:0]  result
);

    localparam logic [RES_W-1:0] FULL_WIDE   = '1;
    localparam logic [RES_W-1:0] FULL_NARROW = {{EXT_W{1'b0}}, {CODE_W{1'b1}}};

    logic              armed;
    logic              hit;
    logic [CODE_W-1:0] gray_lat;
    logic [EXT_W-1:0]  ext_cnt;
    logic [RES_W-1:0]  converted;

    // Gray to binary by XOR prefix from the top bit down.
    function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
        logic [CODE_W-1:0] b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int k = CODE_W - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

    // Form the binary result of the finished window, full scale if unfired.
    always_comb begin
        if (hit) begin
            converted = {ext_cnt & {EXT_W{wide_q}}, gray2bin(gray_lat)};
        end else begin
            converted = wide_q ? FULL_WIDE : FULL_NARROW;
        end
    end

    // Working latch: arm on strobe, capture once, count wraps while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            hit      <= 1'b0;
            gray_lat <= '0;
            ext_cnt  <= '0;
        end else if (arm) begin
            armed   <= 1'b1;
            hit     <= 1'b0;
            ext_cnt <= '0;
        end else begin
            if (busy && armed && comp) begin
                gray_lat <= gray_bus;
                hit      <= 1'b1;
                armed    <= 1'b0;
            end else if (busy && armed && wrap_tick) begin
                ext_cnt <= ext_cnt + 1'b1;
            end
            if (window_end) begin
                armed <= 1'b0;
            end
        end
    end

    // Hold register: loaded only when a finished window is committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (commit) begin
            result <= converted;
        end
    end

endmodule

// File: rtl/stamp_rdmux.sv
// Read port selector over the pixel hold registers.
// Assumes out-of-range addresses read as zero.
module stamp_rdmux #(
    parameter int NPIX  = 64,
    parameter int RES_W = 9,
    localparam int AW   = $clog2(NPIX)
) (
    input  logic [NPIX-1:0][RES_W-1:0] held,
    input  logic [AW-1:0]              rd_addr,
    output logic [RES_W-1:0]           rd_data
);

    // Select the addressed pixel's held result.
    always_comb begin
        rd_data = '0;
        if (32'(rd_addr) < NPIX) begin
            rd_data = held[rd_addr];
        end
    end

endmodule

// File: rtl/slope_stamp_array.sv
// Top of the Gray-timestamp pixel digitizer back end.
// One sequencer broadcasts the timestamp to NPIX pixels; results are read
// through an addressed port. Assumes comparator inputs are already in the
// clk domain.
module slope_stamp_array
    import stamp_pkg::*;
#(
    parameter int NPIX   = ARRAY_PIXELS,
    parameter int CODE_W = STAMP_BITS,
    parameter int EXT_W  = EXTRA_BITS,
    localparam int AW    = $clog2(NPIX),
    localparam int RES_W = CODE_W + EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             wide_mode,
    input  logic [NPIX-1:0]  comp,
    input  logic [AW-1:0]    rd_addr,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             busy
);

    logic                       arm;
    logic                       commit;
    logic                       window_end;
    logic                       wrap_tick;
    logic                       wide_q;
    logic [CODE_W-1:0]          gray_bus;
    logic [NPIX-1:0][RES_W-1:0] held;

    stamp_gen #(.CODE_W(CODE_W), .EXT_W(EXT_W)) i_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .wide_mode    (wide_mode),
        .busy         (busy),
        .arm          (arm),
        .commit       (commit),
        .window_end   (window_end),
        .wrap_tick    (wrap_tick),
        .wide_q       (wide_q),
        .gray_bus     (gray_bus),
        .rd_valid     (rd_valid)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        stamp_pixel #(.CODE_W(CODE_W), .EXT_W(EXT_W)) i_pix (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (arm),
            .commit     (commit),
            .busy       (busy),
            .window_end (window_end),
            .wrap_tick  (wrap_tick),
            .wide_q     (wide_q),
            .gray_bus   (gray_bus),
            .comp       (comp[p]),
            .result     (held[p])
        );
    end

    stamp_rdmux #(.NPIX(NPIX), .RES_W(RES_W)) i_rd (
        .held    (held),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/stamp_chk.sv
// Port-level protocol checker for slope_stamp_array, attached by bind.
// Tracks window length with a counter instead of long delays.
module stamp_chk
    import stamp_pkg::*;
#(
    parameter int NPIX   = 64,
    parameter int CODE_W = 8,
    parameter int EXT_W  = 1,
    localparam int AW    = $clog2(NPIX),
    localparam int RES_W = CODE_W + EXT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_strobe,
    input logic             wide_mode,
    input logic             busy,
    input logic             rd_valid,
    input logic [AW-1:0]    rd_addr,
    input logic [RES_W-1:0] rd_data
);

    int   run_len;
    logic mode_c;
    int   exp_len;

    // Count busy cycles of the current window and note its mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
            mode_c  <= 1'b0;
        end else if (frame_strobe && !busy) begin
            run_len <= 0;
            mode_c  <= wide_mode;
        end else if (busy) begin
            run_len <= run_len + 1;
        end
    end

    // Expected window length for the mode taken at window start.
    always_comb exp_len = window_cycles(CODE_W, EXT_W, mode_c);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !busy) |=> busy);

    p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == exp_len));

    p_strobe_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && busy && (run_len < exp_len - 1)) |=> busy);

    p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_valid);

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(frame_strobe && !busy));

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(frame_strobe && !busy) ##1 $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind slope_stamp_array stamp_chk #(.NPIX(NPIX), .CODE_W(CODE_W), .EXT_W(EXT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .wide_mode    (wide_mode),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data)
);

// File: tb/test_slope_stamp_array.sv
`timescale 1ns/100ps
module test_slope_stamp_array;

    localparam int NPIX = 64;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_strobe = 1'b0;
    logic            wide_mode = 1'b0;
    logic [NPIX-1:0] comp = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [8:0]      rd_data;
    logic            rd_valid;
    logic            busy;

    int    nvec = 0;
    int    nfail = 0;
    int    exp_prev [NPIX];
    bit    exp_valid = 1'b0;
    string prev_tag = "R1";

    always #2.5 clk = ~clk;

    slope_stamp_array i_slope_stamp_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .wide_mode    (wide_mode),
        .comp         (comp),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .busy         (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One window: pixel i first fires at cycle base+step*i; held results of the
    // previous window are read during the first NPIX cycles.
    task automatic run_frame(input bit wide, input int base, input int step,
                             input bit pulse, input bit disturb, input string tag);
        int L;
        int tgt [NPIX];
        L = wide ? 512 : 256;
        for (int i = 0; i < NPIX; i++) tgt[i] = base + step * i;
        @(negedge clk);
        frame_strobe = 1'b1;
        wide_mode = wide;
        comp = '0;
        @(negedge clk);
        frame_strobe = 1'b0;
        check("R2 busy after strobe", int'(busy), 1);
        check("R10 rd_valid", int'(rd_valid), int'(exp_valid));
        for (int t = 0; t < L; t++) begin
            if (t < NPIX) begin
                rd_addr = AW'(t);
                #1;
                check({"R7 R11 ", prev_tag, " held result"}, int'(rd_data), exp_prev[t]);
            end
            for (int i = 0; i < NPIX; i++) begin
                comp[i] = pulse ? ((t == tgt[i]) || (t == tgt[i] + 7)) : (t >= tgt[i]);
            end
            if (disturb && t == L / 2) begin
                frame_strobe = 1'b1;
                wide_mode = ~wide;
            end
            if (disturb && t == L / 2 + 1) frame_strobe = 1'b0;
            if (t == L - 1) check("R2 R8 busy on last cycle", int'(busy), 1);
            @(negedge clk);
        end
        comp = '0;
        frame_strobe = 1'b0;
        wide_mode = wide;
        check("R2 R8 busy cleared after window", int'(busy), 0);
        for (int i = 0; i < NPIX; i++) exp_prev[i] = (tgt[i] < L) ? tgt[i] : L - 1;
        exp_valid = 1'b1;
        prev_tag = tag;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(100000 * 5);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPIX; i++) exp_prev[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        rd_addr = 6'd17;
        #1;
        check("R1 held value after reset", int'(rd_data), 0);

        // Narrow sweeps: codes 0..255 across four windows.
        run_frame(1'b0,   0, 1, 1'b0, 1'b0, "R3");
        run_frame(1'b0,  64, 1, 1'b1, 1'b0, "R3 R6");
        run_frame(1'b0, 128, 1, 1'b0, 1'b1, "R3 R8 R9");
        run_frame(1'b0, 192, 1, 1'b0, 1'b0, "R3");
        run_frame(1'b0, 200, 2, 1'b0, 1'b0, "R5");
        // Wide sweeps: codes 0..511 across eight windows.
        run_frame(1'b1,   0, 1, 1'b0, 1'b0, "R4");
        run_frame(1'b1,  64, 1, 1'b0, 1'b0, "R4");
        run_frame(1'b1, 128, 1, 1'b0, 1'b0, "R4");
        run_frame(1'b1, 192, 1, 1'b1, 1'b0, "R4 R6");
        run_frame(1'b1, 256, 1, 1'b0, 1'b1, "R4 R8 R9");
        run_frame(1'b1, 320, 1, 1'b0, 1'b0, "R4");
        run_frame(1'b1, 384, 1, 1'b0, 1'b0, "R4");
        run_frame(1'b1, 448, 1, 1'b0, 1'b0, "R4");
        run_frame(1'b1, 480, 1, 1'b0, 1'b0, "R5");
        // Flush the last wide window through a narrow one.
        run_frame(1'b0, 600, 1, 1'b0, 1'b0, "R5");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule